// File: doc/BRIEF.md
# Dual-Mode Compute Memory Bank

This block is an 8 KB memory bank that a 32-bit processor reads and writes one word at a time, and that can also run bitwise operations on whole wide rows. The storage is divided into four sub-banks of equal size (2 KB each) whose rows are 64, 128, 256 and 512 bits wide. This covers the 64-bit lanes of a 1600-bit permutation state, a 128-bit block-cipher state, and binary-field elements of 163 to 409 bits. A row-wise command reads one or two rows of one sub-bank and combines them in the read path. It writes the result back to a row of the same sub-bank in a single execute cycle.

A fixed-priority arbiter sits between the word port and the command port. An accepted command raises `busy_o` for its execute cycle. The processor uses that signal to gate its own clock. While a command is pending or executing, the word port is stalled through `bus_ready_o`. The wider datapath (shifters, rotator, substitution box) is a separate block and is not part of this bank.

Top module: `vec_mem_bank`

## Requirements
- R1: The 11-bit word address `bus_addr_i` is split as follows. Bits [10:9] select sub-bank g, whose rows are 64<<g bits wide. The low g+1 bits of `bus_addr_i[8:0]` pick the 32-bit lane, where lane l is row bits [32l+31:32l]. The remaining upper bits of `bus_addr_i[8:0]` pick the row. A granted read shows the addressed word on `bus_rdata_o` one cycle after the grant edge.
- R2: On a granted write, bit k of `bus_be_i` enables byte k (bits [8k+7:8k]) of the addressed word. Bytes whose enable bit is clear keep their value.
- R3: A command with `cmd_op_i` equal to 0, 1, 2, 3 or 4 writes a whole row `cmd_row_d_i` of sub-bank `cmd_sb_i`. The value written is, in that order of codes: row A unchanged, NOT row A, A OR B, A AND B, or A XOR B. Row A is `cmd_row_a_i` and row B is `cmd_row_b_i`, both read before the write, so in-place operations use the old values.
- R4: A command with `cmd_op_i` equal to 5, 6 or 7 changes no row.
- R5: A command is accepted on an edge where `cmd_valid_i` and `cmd_ready_o` are both high. `busy_o` is then high for exactly the next cycle, the result is written at the end of that cycle, and `cmd_ready_o` is low while `busy_o` is high.
- R6: `bus_ready_o` is low whenever `cmd_valid_i` or `busy_o` is high, so commands have priority. A word access held through the stall takes effect only after the command has executed.
- R7: `bus_rdata_o` holds its value on every edge that grants no read.
- R8: After reset, `busy_o` is low, `cmd_ready_o` is high, `bus_rdata_o` is zero, and `bus_ready_o` is high while no command is requested.
- R9: A command changes only its destination row. Other rows of the same sub-bank and all other sub-banks are left unchanged.
- R10: The row fields of a command are taken modulo the row count of the selected sub-bank (the low bits are used).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Word access request |
| bus_we_i | input | 1 | Word access is a write |
| bus_addr_i | input | 11 | Word address |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Word access granted this cycle; low means wait |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read grant |
| cmd_valid_i | input | 1 | Row command request |
| cmd_ready_o | output | 1 | Command port can accept |
| cmd_op_i | input | 3 | Operation code |
| cmd_sb_i | input | 2 | Sub-bank select |
| cmd_row_a_i | input | 8 | Source row A |
| cmd_row_b_i | input | 8 | Source row B |
| cmd_row_d_i | input | 8 | Destination row |
| busy_o | output | 1 | Command executing; gates the processor clock |

## Verification
A wrong arbiter state shows at the ports within one cycle: `busy_o` stays high too long, or `bus_ready_o` rises while a command is still pending. A wrong opcode decode, a wrong row index or a wrong lane mapping stays hidden in the array. It becomes visible only when the affected row is read back word by word, and that readback comes a few cycles after the command. The bench therefore reads back the destination row and its neighbours after every command. A mis-ordered stall shows up as the wrong winner in a word that both the command and a held bus write touch.

// File: rtl/vmb_pkg.sv
package vmb_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    VOP_PASS = 3'd0,
    VOP_INV  = 3'd1,
    VOP_OR   = 3'd2,
    VOP_AND  = 3'd3,
    VOP_XOR  = 3'd4
  } vop_e;
endpackage

// File: rtl/vmb_vec_alu.sv
module vmb_vec_alu
  import vmb_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    res_o,
  output logic            wr_ok_o
);
  always_comb begin
    wr_ok_o = 1'b1;
    case (op_i)
      VOP_PASS: res_o = a_i;
      VOP_INV:  res_o = ~a_i;
      VOP_OR:   res_o = a_i | b_i;
      VOP_AND:  res_o = a_i & b_i;
      VOP_XOR:  res_o = a_i ^ b_i;
      default: begin
        res_o   = '0;
        wr_ok_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/vmb_subbank.sv
module vmb_subbank
  import vmb_pkg::*;
#(
  parameter int W        = 64,
  parameter int SB_BYTES = 2048,
  parameter int IDX_W    = $clog2(SB_BYTES / 4),
  parameter int RB       = $clog2(SB_BYTES * 8 / W)
) (
  input  logic             clk_i,
  input  logic             w_en_i,
  input  logic             w_we_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic [3:0]       w_be_i,
  input  logic [31:0]      w_data_i,
  output logic [31:0]      w_rdata_o,
  input  logic             v_en_i,
  input  logic [OP_W-1:0]  v_op_i,
  input  logic [RB-1:0]    v_ra_i,
  input  logic [RB-1:0]    v_rb_i,
  input  logic [RB-1:0]    v_rd_i
);
  localparam int LANES = W / 32;
  localparam int LB    = $clog2(LANES);
  localparam int ROWS  = SB_BYTES * 8 / W;

  logic [W-1:0]  mem [ROWS];
  logic [RB-1:0] w_row;
  logic [LB-1:0] w_lane;
  logic [W-1:0]  v_res;
  logic          v_ok;

  assign w_row     = w_idx_i[IDX_W-1:LB];
  assign w_lane    = w_idx_i[LB-1:0];
  assign w_rdata_o = mem[w_row][32*w_lane +: 32];

  vmb_vec_alu #(.W(W)) u_alu (
    .op_i   (v_op_i),
    .a_i    (mem[v_ra_i]),
    .b_i    (mem[v_rb_i]),
    .res_o  (v_res),
    .wr_ok_o(v_ok)
  );

  // arbiter never enables both ports in one cycle
  always_ff @(posedge clk_i) begin
    if (v_en_i) begin
      if (v_ok) mem[v_rd_i] <= v_res;
    end else if (w_en_i && w_we_i) begin
      for (int b = 0; b < 4; b++) begin
        if (w_be_i[b]) mem[w_row][32*w_lane + 8*b +: 8] <= w_data_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/vmb_arbiter.sv
module vmb_arbiter #(
  parameter int CMD_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             bus_req_i,
  output logic             cmd_ready_o,
  output logic             bus_ready_o,
  output logic             bus_gnt_o,
  output logic             exec_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic busy_q;

  assign cmd_ready_o = ~busy_q;
  assign bus_ready_o = ~busy_q & ~cmd_valid_i;
  assign bus_gnt_o   = bus_req_i & bus_ready_o;
  assign exec_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_o  <= '0;
    end else begin
      busy_q <= cmd_valid_i & ~busy_q;
      if (cmd_valid_i && !busy_q) cmd_o <= cmd_i;
    end
  end
endmodule

// File: rtl/vec_mem_bank.sv
module vec_mem_bank
  import vmb_pkg::*;
#(
  parameter int NUM_SB   = 4,
  parameter int BASE_W   = 64,
  parameter int SB_BYTES = 2048,
  parameter int ROW_AW   = 8
) (
  input  logic                                              clk_i,
  input  logic                                              rst_ni,
  input  logic                                              bus_req_i,
  input  logic                                              bus_we_i,
  input  logic [$clog2(NUM_SB)+$clog2(SB_BYTES/4)-1:0]      bus_addr_i,
  input  logic [3:0]                                        bus_be_i,
  input  logic [31:0]                                       bus_wdata_i,
  output logic                                              bus_ready_o,
  output logic [31:0]                                       bus_rdata_o,
  input  logic                                              cmd_valid_i,
  output logic                                              cmd_ready_o,
  input  logic [OP_W-1:0]                                   cmd_op_i,
  input  logic [$clog2(NUM_SB)-1:0]                         cmd_sb_i,
  input  logic [ROW_AW-1:0]                                 cmd_row_a_i,
  input  logic [ROW_AW-1:0]                                 cmd_row_b_i,
  input  logic [ROW_AW-1:0]                                 cmd_row_d_i,
  output logic                                              busy_o
);
  localparam int SB_SEL_W = $clog2(NUM_SB);
  localparam int IDX_W    = $clog2(SB_BYTES / 4);
  localparam int ADDR_W   = SB_SEL_W + IDX_W;
  localparam int CMD_W    = OP_W + SB_SEL_W + 3 * ROW_AW;

  logic                bus_gnt, exec;
  logic [CMD_W-1:0]    cmd_q;
  logic [OP_W-1:0]     q_op;
  logic [SB_SEL_W-1:0] q_sb;
  logic [ROW_AW-1:0]   q_ra, q_rb, q_rd;
  logic [SB_SEL_W-1:0] bus_sb;
  logic [31:0]         sb_rdata [NUM_SB];
  logic [31:0]         rdata_q;

  vmb_arbiter #(.CMD_W(CMD_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      ({cmd_op_i, cmd_sb_i, cmd_row_a_i, cmd_row_b_i, cmd_row_d_i}),
    .bus_req_i  (bus_req_i),
    .cmd_ready_o(cmd_ready_o),
    .bus_ready_o(bus_ready_o),
    .bus_gnt_o  (bus_gnt),
    .exec_o     (exec),
    .cmd_o      (cmd_q)
  );

  assign {q_op, q_sb, q_ra, q_rb, q_rd} = cmd_q;
  assign bus_sb = bus_addr_i[ADDR_W-1:IDX_W];
  assign busy_o = exec;

  for (genvar g = 0; g < NUM_SB; g++) begin : g_sb
    localparam int SW = BASE_W << g;
    localparam int RB = $clog2(SB_BYTES * 8 / SW);

    vmb_subbank #(.W(SW), .SB_BYTES(SB_BYTES), .IDX_W(IDX_W), .RB(RB)) u_sb (
      .clk_i    (clk_i),
      .w_en_i   (bus_gnt && bus_sb == SB_SEL_W'(g)),
      .w_we_i   (bus_we_i),
      .w_idx_i  (bus_addr_i[IDX_W-1:0]),
      .w_be_i   (bus_be_i),
      .w_data_i (bus_wdata_i),
      .w_rdata_o(sb_rdata[g]),
      .v_en_i   (exec && q_sb == SB_SEL_W'(g)),
      .v_op_i   (q_op),
      .v_ra_i   (q_ra[RB-1:0]),
      .v_rb_i   (q_rb[RB-1:0]),
      .v_rd_i   (q_rd[RB-1:0])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_q <= '0;
    else if (bus_gnt && !bus_we_i) rdata_q <= sb_rdata[bus_sb];
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/vmb_checker.sv
module vmb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_i,
  input logic        bus_we_i,
  input logic        bus_ready_o,
  input logic [31:0] bus_rdata_o,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic        busy_o
);
  AST_BUSY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> busy_o); // R5
  AST_BUSY_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $past(cmd_valid_i)); // R5
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!cmd_ready_o && !bus_ready_o)); // R6
  AST_CMD_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !bus_ready_o); // R6
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_valid_i) |-> (bus_ready_o && cmd_ready_o)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_ready_o && !bus_we_i) |=> $stable(bus_rdata_o)); // R7

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!busy_o && bus_rdata_o == 32'd0); // R8
    end
  end
endmodule

bind vec_mem_bank vmb_checker u_vmb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_ready_o(bus_ready_o),
  .bus_rdata_o(bus_rdata_o),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .busy_o     (busy_o)
);

// File: tb/vec_mem_bank_bench.sv
module vec_mem_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_sb = '0;
  logic [7:0]  cmd_ra = '0, cmd_rb = '0, cmd_rd = '0;
  logic        busy;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vec_mem_bank u_vec_mem_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata),
    .bus_ready_o(bus_ready), .bus_rdata_o(bus_rdata),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_sb_i(cmd_sb), .cmd_row_a_i(cmd_ra), .cmd_row_b_i(cmd_rb),
    .cmd_row_d_i(cmd_rd), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input int g);
    return (64 << g) / 32;
  endfunction

  function automatic logic [10:0] addr_of(input int g, input int r, input int l);
    int rows = 16384 / (64 << g);
    return 11'((g << 9) | (((r % rows) << (g + 1)) | l));
  endfunction

  function automatic logic [511:0] mask_of(input int g);
    return {512{1'b1}} >> (512 - (64 << g));
  endfunction

  function automatic logic [511:0] pat(input int seed);
    logic [511:0] v;
    for (int i = 0; i < 16; i++)
      v[32*i +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h01010101) ^ 32'(i + seed);
    return v;
  endfunction

  function automatic logic [511:0] ref_op(input int op, input logic [511:0] a, input logic [511:0] b, input int g);
    case (op)
      0: return a & mask_of(g);
      1: return ~a & mask_of(g);
      2: return (a | b) & mask_of(g);
      3: return (a & b) & mask_of(g);
      default: return (a ^ b) & mask_of(g);
    endcase
  endfunction

  task automatic bus_write(input logic [10:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic write_row(input int g, input int r, input logic [511:0] v);
    for (int l = 0; l < lanes_of(g); l++) bus_write(addr_of(g, r, l), 4'hF, v[32*l +: 32]);
  endtask

  task automatic read_row(input int g, input int r, output logic [511:0] v);
    logic [31:0] w;
    v = '0;
    for (int l = 0; l < lanes_of(g); l++) begin
      bus_read(addr_of(g, r, l), w);
      v[32*l +: 32] = w;
    end
  endtask

  task automatic run_cmd(input int op, input int g, input int ra, input int rb, input int rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_sb = 2'(g);
    cmd_ra = 8'(ra); cmd_rb = 8'(rb); cmd_rd = 8'(rd);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy in execute cycle", 512'(busy), 512'(1));
    chk("R5 cmd_ready low while busy", 512'(cmd_ready), 512'(0));
    @(negedge clk);
    chk("R5 busy drops after one cycle", 512'(busy), 512'(0));
  endtask

  task automatic t_reset;
    chk("R8 busy after reset", 512'(busy), 512'(0));
    chk("R8 cmd_ready after reset", 512'(cmd_ready), 512'(1));
    chk("R8 bus_ready after reset", 512'(bus_ready), 512'(1));
    chk("R8 rdata after reset", 512'(bus_rdata), 512'(0));
  endtask

  task automatic t_word_rw;
    logic [31:0] d;
    bus_write(11'd0, 4'hF, 32'hCAFE0001);
    bus_write(11'd2047, 4'hF, 32'hBEEF07FF);
    bus_write(11'd513, 4'hF, 32'h12340201);
    bus_write(11'd1030, 4'hF, 32'h56780406);
    bus_read(11'd0, d);    chk("R1 word at address 0", 512'(d), 512'(32'hCAFE0001));
    bus_read(11'd2047, d); chk("R1 word at last address", 512'(d), 512'(32'hBEEF07FF));
    bus_read(11'd513, d);  chk("R1 word in sub-bank 1", 512'(d), 512'(32'h12340201));
    bus_read(11'd1030, d); chk("R1 word in sub-bank 2", 512'(d), 512'(32'h56780406));
  endtask

  task automatic t_byte_en;
    logic [31:0] d;
    bus_write(11'd700, 4'hF, 32'hAABBCCDD);
    bus_write(11'd700, 4'b0101, 32'h11223344);
    bus_read(11'd700, d); chk("R2 partial byte write", 512'(d), 512'(32'hAA22CC44));
    bus_write(11'd700, 4'b0000, 32'h99999999);
    bus_read(11'd700, d); chk("R2 no byte enabled", 512'(d), 512'(32'hAA22CC44));
    bus_write(11'd700, 4'b1000, 32'h5F000000);
    bus_read(11'd700, d); chk("R2 top byte only", 512'(d), 512'(32'h5F22CC44));
  endtask

  task automatic t_vec_ops;
    logic [511:0] a, b, v, nb, oth;
    for (int g = 0; g < 4; g++) begin
      a = pat(10 + g) & mask_of(g);
      b = pat(20 + g) & mask_of(g);
      nb = pat(30 + g) & mask_of(g ^ 1);
      oth = pat(40 + g) & mask_of(g ^ 1);
      write_row(g, 3, a);
      write_row(g, 5, b);
      write_row(g, 8, pat(50 + g) & mask_of(g));
      write_row(g ^ 1, 7, oth);
      for (int op = 0; op < 5; op++) begin
        write_row(g, 7, pat(60 + op) & mask_of(g));
        run_cmd(op, g, 3, 5, 7);
        read_row(g, 7, v);
        chk($sformatf("R3 op %0d sub-bank %0d", op, g), v, ref_op(op, a, b, g));
      end
      read_row(g, 3, v);     chk("R9 source row A unchanged", v, a);
      read_row(g, 8, v);     chk("R9 neighbour row unchanged", v, pat(50 + g) & mask_of(g));
      read_row(g ^ 1, 7, v); chk("R9 other sub-bank unchanged", v, oth);
    end
    // in-place: A = B = D uses old values
    write_row(1, 9, pat(77) & mask_of(1));
    run_cmd(4, 1, 9, 9, 9);
    read_row(1, 9, v); chk("R3 in-place xor clears row", v, 512'(0));
    write_row(2, 9, pat(78) & mask_of(2));
    run_cmd(1, 2, 9, 9, 9);
    read_row(2, 9, v); chk("R3 in-place invert", v, ~pat(78) & mask_of(2));
  endtask

  task automatic t_reserved;
    logic [511:0] v;
    write_row(1, 12, pat(90) & mask_of(1));
    write_row(1, 13, pat(91) & mask_of(1));
    for (int op = 5; op < 8; op++) begin
      run_cmd(op, 1, 13, 13, 12);
      read_row(1, 12, v);
      chk($sformatf("R4 reserved op %0d leaves row", op), v, pat(90) & mask_of(1));
    end
  endtask

  task automatic t_wrap;
    logic [511:0] v;
    write_row(3, 3, pat(100));
    write_row(3, 1, pat(101));
    run_cmd(0, 3, 35, 35, 33);
    read_row(3, 1, v); chk("R10 row fields wrap modulo 32", v, pat(100));
  endtask

  task automatic t_stall;
    logic [511:0] v, e;
    write_row(2, 2, pat(110) & mask_of(2));
    write_row(2, 4, '0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_sb = 2'd2; cmd_ra = 8'd2; cmd_rb = 8'd2; cmd_rd = 8'd4;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = addr_of(2, 4, 0); bus_be = 4'hF; bus_wdata = 32'h0BADF00D;
    #0;
    chk("R6 bus stalled by pending command", 512'(bus_ready), 512'(0));
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 bus stalled while busy", 512'(bus_ready), 512'(0));
    chk("R5 busy during stall", 512'(busy), 512'(1));
    @(negedge clk);
    chk("R6 bus granted after command", 512'(bus_ready), 512'(1));
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    read_row(2, 4, v);
    e = pat(110) & mask_of(2);
    e[31:0] = 32'h0BADF00D;
    chk("R6 held write lands after command", v, e);
  endtask

  task automatic t_rdata_hold;
    logic [31:0] d;
    bus_write(11'd1500, 4'hF, 32'h600DCAFE);
    bus_read(11'd1500, d);
    bus_write(11'd1501, 4'hF, 32'h01020304);
    run_cmd(2, 0, 1, 2, 3);
    chk("R7 rdata held over writes and commands", 512'(bus_rdata), 512'(32'h600DCAFE));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_word_rw;
    t_byte_en;
    t_vec_ops;
    t_reserved;
    t_wrap;
    t_stall;
    t_rdata_hold;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule